// File: doc/BRIEF.md
# USB Device Link State Controller

This block follows the bus-level life cycle of a full-speed USB device: powered, default, addressed, and suspended. It takes the decoded two-bit line state from the transceiver and a few register-style control bits. From these it decides when the device pull-up is applied, when a bus reset has occurred, when the bus has been idle long enough to enter suspend, and when the device leaves suspend again. It also stores the device address that firmware assigns and tells the token decoder whether an incoming token address belongs to this device.

Suspend entry takes two equal idle windows. The first window raises an early-suspend flag. The second raises the suspend flag and sets the suspend status. Idle time is counted in microsecond ticks, which are divided down from the system clock. Remote wakeup is timed by firmware: the block drives a K state for as long as the request bit stays set in the suspended state. Three sticky interrupt flags are cleared by writing 1. They are gated by a mask into a single interrupt line.

Top module: `usb_link_state_ctl`

States:
- POWERED (code 0): entered from reset and from soft disconnect.
- DEFAULT (code 1): entered on bus reset.
- ADDRESS (code 2): entered when a nonzero address is written in DEFAULT.
- SUSPEND (code 3): entered from the other three states on the suspend event.

Transitions:
- Soft disconnect goes to POWERED from any state.
- Bus reset goes to DEFAULT from any state while the pull-up is on.
- Suspend entry goes from POWERED, DEFAULT or ADDRESS to SUSPEND.
- Resume goes from SUSPEND back to the state it was entered from.
- Address set goes from DEFAULT to ADDRESS.
- Address clear goes from ADDRESS to DEFAULT when the written address is zero.

## Requirements
- R1: While `soft_disc` is 1, `pullup_en` is 0 one cycle later, the state becomes POWERED (`link_state` 0), and `dev_addr` becomes 0. While `soft_disc` is 0, `pullup_en` is 1 one cycle later. After reset, `link_state` is 0 and all outputs are 0.
- R2: `line_state` uses the codes 0 = SE0, 1 = J (idle), 2 = K and 3 = SE1. If SE0 lasts RST_CYC consecutive cycles while the pull-up is on, the block goes to DEFAULT (`link_state` 1) from any state, clears `dev_addr` and clears `susp_sts`. RST_CYC is the first cycle count of at least 2.5 µs. A shorter SE0 has no effect.
- R3: An `addr_wr` pulse with a nonzero `addr_val` in DEFAULT stores the address and moves the block to ADDRESS (`link_state` 2). In ADDRESS, a write stores the new address, and a write of zero returns the block to DEFAULT. Writes in POWERED and SUSPEND are ignored.
- R4: `tok_match` is `tok_valid` combined with an address condition. In DEFAULT the condition is that `tok_addr` is 0. In ADDRESS the condition is that `tok_addr` equals `dev_addr`. In the other states `tok_match` is 0.
- R5: After IDLE_US microseconds of continuous J, flag bit 0 (early suspend) of `int_flags` is set. This applies while the pull-up is on and the block is not suspended.
- R6: If J continues for another IDLE_US microseconds, flag bit 1 (suspend) is set. On the same clock edge `susp_sts` becomes 1 and the state becomes SUSPEND.
- R7: Any line state other than J restarts both idle windows from zero.
- R8: In SUSPEND, a K on the line while `rwkup_req` is 0 does four things on one edge: it sets flag bit 2 (wake), clears `susp_sts`, and returns the block to the state it held before suspend with `dev_addr` kept.
- R9: `drive_k` is 1 only while the block is in SUSPEND and `rwkup_req` is 1. It follows `rwkup_req` with one cycle of latency. When the block is not suspended, `rwkup_req` is ignored.
- R10: Flags stay set until a 1 is written on the matching `int_clr` bit. If a flag is set and cleared in the same cycle, the set wins.
- R11: `irq` is 1 exactly when some flag is set and its `int_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Decoded line: 0 SE0, 1 J, 2 K, 3 SE1 |
| soft_disc | input | 1 | Soft disconnect control bit |
| addr_wr | input | 1 | One-cycle address write strobe |
| addr_val | input | ADDR_W | Address written by firmware |
| rwkup_req | input | 1 | Remote wakeup request bit |
| tok_valid | input | 1 | Token address present |
| tok_addr | input | ADDR_W | Address field of the incoming token |
| int_clr | input | 3 | Write-1-to-clear strobes for the flags |
| int_mask | input | 3 | Interrupt enable per flag |
| pullup_en | output | 1 | D+ pull-up enable |
| drive_k | output | 1 | Request to drive K on the bus |
| susp_sts | output | 1 | Suspend status bit |
| link_state | output | 2 | Current state code |
| dev_addr | output | ADDR_W | Stored device address |
| tok_match | output | 1 | Token is addressed to this device |
| int_flags | output | 3 | Sticky flags: 0 early suspend, 1 suspend, 2 wake |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two things can land in the same cycle: the early-suspend event setting flag 0, and firmware clearing that flag. To provoke this, the bench holds the clear strobe for flag 0 high through the whole first idle window. While the clear is held, the flag may be 1 only at the edge where the event fires, and is cleared at the next edge. The bench samples the flag on every cycle of the window and requires exactly one sample with the flag set. A design where the clear wins would show no such cycle. A design that ignores the clear would show many.

// File: rtl/usb_link_pkg.sv
`timescale 1ns/1ps
package usb_link_pkg;

    typedef enum logic [1:0] {
        LS_POWERED = 2'd0,
        LS_DEFAULT = 2'd1,
        LS_ADDRESS = 2'd2,
        LS_SUSPEND = 2'd3
    } link_st_e;

    localparam logic [1:0] LINE_SE0 = 2'd0;
    localparam logic [1:0] LINE_J   = 2'd1;
    localparam logic [1:0] LINE_K   = 2'd2;

    localparam int ADDR_W     = 7;
    localparam int NUM_FLAGS  = 3;
    localparam int FLG_EARLY  = 0;
    localparam int FLG_SUSP   = 1;
    localparam int FLG_WAKE   = 2;

endpackage

// File: rtl/usb_idle_timer.sv
`timescale 1ns/1ps
module usb_idle_timer #(
    parameter int CLK_PER_US = 60,
    parameter int IDLE_US    = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic line_j,
    output logic early_evt,
    output logic susp_evt
);
    localparam int PRE_W   = $clog2(CLK_PER_US + 1);
    localparam int CNT_MAX = 2 * IDLE_US;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             tick;

    assign run  = arm && line_j;
    assign tick = run && (pre_q == PRE_W'(CLK_PER_US - 1));

    // microsecond prescaler, restarted whenever the line leaves idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // idle time in microseconds, saturating after the second window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign early_evt = tick && (cnt_q == CNT_W'(IDLE_US - 1));
    assign susp_evt  = tick && (cnt_q == CNT_W'(CNT_MAX - 1));

endmodule

// File: rtl/usb_se0_watch.sv
`timescale 1ns/1ps
module usb_se0_watch #(
    parameter int RST_CYC = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_se0,
    output logic bus_rst_evt
);
    localparam int CNT_W = $clog2(RST_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!(enable && line_se0)) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(RST_CYC)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // fires once per SE0 episode, on the cycle the length threshold is met
    assign bus_rst_evt = enable && line_se0 && (cnt_q == CNT_W'(RST_CYC - 1));

endmodule

// File: rtl/usb_link_fsm.sv
`timescale 1ns/1ps
module usb_link_fsm
    import usb_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_disc,
    input  logic              bus_rst_evt,
    input  logic              susp_evt,
    input  logic              line_k,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              rwkup_req,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    output link_st_e          state,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              wake_evt,
    output logic              tok_match,
    output logic              pullup_en,
    output logic              drive_k,
    output logic              susp_sts
);
    link_st_e          state_q, state_n;
    link_st_e          ret_q, ret_n;
    logic [ADDR_W-1:0] addr_q, addr_n;

    assign wake_evt = (state_q == LS_SUSPEND) && line_k && !rwkup_req
                      && !soft_disc && !bus_rst_evt;

    always_comb begin
        state_n = state_q;
        ret_n   = ret_q;
        addr_n  = addr_q;
        if (soft_disc) begin
            state_n = LS_POWERED;
            addr_n  = '0;
        end else if (bus_rst_evt) begin
            state_n = LS_DEFAULT;
            addr_n  = '0;
        end else begin
            unique case (state_q)
                LS_POWERED: begin
                    if (susp_evt) begin
                        ret_n   = LS_POWERED;
                        state_n = LS_SUSPEND;
                    end
                end
                LS_DEFAULT: begin
                    if (susp_evt) begin
                        ret_n   = LS_DEFAULT;
                        state_n = LS_SUSPEND;
                    end else if (addr_wr && addr_val != '0) begin
                        addr_n  = addr_val;
                        state_n = LS_ADDRESS;
                    end
                end
                LS_ADDRESS: begin
                    if (susp_evt) begin
                        ret_n   = LS_ADDRESS;
                        state_n = LS_SUSPEND;
                    end else if (addr_wr) begin
                        addr_n  = addr_val;
                        state_n = (addr_val == '0) ? LS_DEFAULT : LS_ADDRESS;
                    end
                end
                LS_SUSPEND: begin
                    if (wake_evt) begin
                        state_n = ret_q;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_POWERED;
            ret_q   <= LS_POWERED;
            addr_q  <= '0;
        end else begin
            state_q <= state_n;
            ret_q   <= ret_n;
            addr_q  <= addr_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pullup_en <= 1'b0;
            drive_k   <= 1'b0;
            susp_sts  <= 1'b0;
        end else begin
            pullup_en <= !soft_disc;
            susp_sts  <= (state_n == LS_SUSPEND);
            drive_k   <= (state_n == LS_SUSPEND) && rwkup_req;
        end
    end

    always_comb begin
        unique case (state_q)
            LS_DEFAULT: tok_match = tok_valid && (tok_addr == '0);
            LS_ADDRESS: tok_match = tok_valid && (tok_addr == addr_q);
            default:    tok_match = 1'b0;
        endcase
    end

    assign state    = state_q;
    assign dev_addr = addr_q;

endmodule

// File: rtl/usb_int_flags.sv
`timescale 1ns/1ps
module usb_int_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set[i]) begin
                bit_q <= 1'b1;
            end else if (clr[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[i] = bit_q;
    end

    assign irq = |(flags & mask);

endmodule

// File: rtl/usb_link_state_ctl.sv
`timescale 1ns/1ps
module usb_link_state_ctl
    import usb_link_pkg::*;
#(
    parameter int CLK_PER_US = 60,
    parameter int IDLE_US    = 3000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           line_state,
    input  logic                 soft_disc,
    input  logic                 addr_wr,
    input  logic [ADDR_W-1:0]    addr_val,
    input  logic                 rwkup_req,
    input  logic                 tok_valid,
    input  logic [ADDR_W-1:0]    tok_addr,
    input  logic [NUM_FLAGS-1:0] int_clr,
    input  logic [NUM_FLAGS-1:0] int_mask,
    output logic                 pullup_en,
    output logic                 drive_k,
    output logic                 susp_sts,
    output logic [1:0]           link_state,
    output logic [ADDR_W-1:0]    dev_addr,
    output logic                 tok_match,
    output logic [NUM_FLAGS-1:0] int_flags,
    output logic                 irq
);
    localparam int RST_CYC = (CLK_PER_US * 5 + 1) / 2;

    link_st_e             state;
    logic                 early_evt;
    logic                 susp_evt;
    logic                 wake_evt;
    logic                 bus_rst_evt;
    logic                 arm;
    logic [NUM_FLAGS-1:0] flag_set;

    assign arm = pullup_en && !soft_disc && (state != LS_SUSPEND);

    usb_idle_timer #(
        .CLK_PER_US (CLK_PER_US),
        .IDLE_US    (IDLE_US)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .line_j    (line_state == LINE_J),
        .early_evt (early_evt),
        .susp_evt  (susp_evt)
    );

    usb_se0_watch #(
        .RST_CYC (RST_CYC)
    ) u_se0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (pullup_en && !soft_disc),
        .line_se0    (line_state == LINE_SE0),
        .bus_rst_evt (bus_rst_evt)
    );

    usb_link_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_disc   (soft_disc),
        .bus_rst_evt (bus_rst_evt),
        .susp_evt    (susp_evt),
        .line_k      (line_state == LINE_K),
        .addr_wr     (addr_wr),
        .addr_val    (addr_val),
        .rwkup_req   (rwkup_req),
        .tok_valid   (tok_valid),
        .tok_addr    (tok_addr),
        .state       (state),
        .dev_addr    (dev_addr),
        .wake_evt    (wake_evt),
        .tok_match   (tok_match),
        .pullup_en   (pullup_en),
        .drive_k     (drive_k),
        .susp_sts    (susp_sts)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLG_EARLY] = early_evt;
        flag_set[FLG_SUSP]  = susp_evt;
        flag_set[FLG_WAKE]  = wake_evt;
    end

    usb_int_flags #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (int_clr),
        .mask  (int_mask),
        .flags (int_flags),
        .irq   (irq)
    );

    assign link_state = state;

endmodule

// File: rtl/usb_link_state_ctl_chk.sv
`timescale 1ns/1ps
module usb_link_state_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_disc,
    input logic       bus_rst_evt,
    input logic       early_evt,
    input logic       susp_evt,
    input logic       wake_evt,
    input logic       pullup_en,
    input logic       drive_k,
    input logic       susp_sts,
    input logic [1:0] link_state,
    input logic [6:0] dev_addr,
    input logic [2:0] int_flags,
    input logic [2:0] int_clr
);
    a_r1_pullup_off: assert property (@(posedge clk) disable iff (!rst_n)
        soft_disc |=> !pullup_en);

    a_r2_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_evt && !soft_disc) |=> (dev_addr == 7'd0 && link_state == 2'd1 && !susp_sts));

    a_r5_stages_apart: assert property (@(posedge clk) disable iff (!rst_n)
        early_evt |-> !susp_evt);

    a_r6_susp_status: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_evt && !soft_disc && !bus_rst_evt) |=> (susp_sts && int_flags[1] && link_state == 2'd3));

    a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (!susp_sts && int_flags[2]));

    a_r9_k_only_suspended: assert property (@(posedge clk) disable iff (!rst_n)
        drive_k |-> (susp_sts && link_state == 2'd3));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flags[0] && !int_clr[0]) |=> int_flags[0]);

endmodule

bind usb_link_state_ctl usb_link_state_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_disc   (soft_disc),
    .bus_rst_evt (bus_rst_evt),
    .early_evt   (early_evt),
    .susp_evt    (susp_evt),
    .wake_evt    (wake_evt),
    .pullup_en   (pullup_en),
    .drive_k     (drive_k),
    .susp_sts    (susp_sts),
    .link_state  (link_state),
    .dev_addr    (dev_addr),
    .int_flags   (int_flags),
    .int_clr     (int_clr)
);

// File: tb/test_usb_link_state_ctl.sv
`timescale 1ns/1ps
module test_usb_link_state_ctl;

    localparam int CPU = 4;
    localparam int IUS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = 2'd2;
    logic       soft_disc = 1'b1;
    logic       addr_wr = 1'b0;
    logic [6:0] addr_val = '0;
    logic       rwkup_req = 1'b0;
    logic       tok_valid = 1'b0;
    logic [6:0] tok_addr = '0;
    logic [2:0] int_clr = '0;
    logic [2:0] int_mask = '0;
    logic       pullup_en, drive_k, susp_sts, tok_match, irq;
    logic [1:0] link_state;
    logic [6:0] dev_addr;
    logic [2:0] int_flags;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    usb_link_state_ctl #(.CLK_PER_US(CPU), .IDLE_US(IUS)) i_usb_link_state_ctl (
        .clk(clk), .rst_n(rst_n), .line_state(line_state), .soft_disc(soft_disc),
        .addr_wr(addr_wr), .addr_val(addr_val), .rwkup_req(rwkup_req),
        .tok_valid(tok_valid), .tok_addr(tok_addr), .int_clr(int_clr),
        .int_mask(int_mask), .pullup_en(pullup_en), .drive_k(drive_k),
        .susp_sts(susp_sts), .link_state(link_state), .dev_addr(dev_addr),
        .tok_match(tok_match), .int_flags(int_flags), .irq(irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bus_reset();
        line_state = 2'd0; cyc(14); line_state = 2'd2; cyc(2);
    endtask

    task automatic write_addr(input logic [6:0] a);
        addr_val = a; addr_wr = 1'b1; cyc(1); addr_wr = 1'b0; cyc(1);
    endtask

    task automatic t_reset_state();
        chk("R1 reset link_state", link_state, 0);
        chk("R1 reset pullup", pullup_en, 0);
        chk("R1 reset flags", int_flags, 0);
        chk("R1 reset addr", dev_addr, 0);
    endtask

    task automatic t_pullup();
        soft_disc = 1'b0; cyc(2);
        chk("R1 pullup on", pullup_en, 1);
    endtask

    task automatic t_bus_reset();
        line_state = 2'd0; cyc(6); line_state = 2'd2; cyc(2);
        chk("R2 short SE0 ignored", link_state, 0);
        bus_reset();
        chk("R2 long SE0 to default", link_state, 1);
    endtask

    task automatic t_address();
        tok_valid = 1'b1; tok_addr = 7'h00; #0.1;
        chk("R4 default matches addr 0", tok_match, 1);
        write_addr(7'h2A);
        chk("R3 addressed state", link_state, 2);
        chk("R3 address stored", dev_addr, 7'h2A);
        tok_addr = 7'h2A; #0.1;
        chk("R4 own address match", tok_match, 1);
        tok_addr = 7'h00; #0.1;
        chk("R4 addr 0 no match when addressed", tok_match, 0);
        tok_valid = 1'b0;
    endtask

    task automatic t_soft_disc();
        soft_disc = 1'b1; cyc(2);
        chk("R1 pullup off", pullup_en, 0);
        chk("R1 to powered", link_state, 0);
        chk("R1 address cleared", dev_addr, 0);
        write_addr(7'h11);
        chk("R3 write ignored in powered", dev_addr, 0);
        chk("R3 state kept powered", link_state, 0);
        soft_disc = 1'b0; cyc(2);
        bus_reset();
        write_addr(7'h05);
        chk("R3 readdressed", link_state, 2);
    endtask

    task automatic t_idle_break();
        line_state = 2'd1; cyc(30);
        line_state = 2'd2; cyc(2);
        line_state = 2'd1; cyc(30);
        chk("R7 broken idle no early flag", int_flags[0], 0);
        line_state = 2'd2; cyc(2);
    endtask

    task automatic t_suspend();
        line_state = 2'd1;
        cyc(36);
        chk("R5 early flag not yet", int_flags[0], 0);
        cyc(8);
        chk("R5 early flag set", int_flags[0], 1);
        chk("R6 not suspended after first window", susp_sts, 0);
        cyc(32);
        chk("R6 suspend flag not yet", int_flags[1], 0);
        cyc(8);
        chk("R6 suspend flag set", int_flags[1], 1);
        chk("R6 suspend status", susp_sts, 1);
        chk("R6 suspend state", link_state, 3);
        chk("R11 irq masked off", irq, 0);
        int_mask = 3'b010; #0.1;
        chk("R11 irq unmasked", irq, 1);
        int_mask = 3'b000;
    endtask

    task automatic t_remote_wakeup();
        rwkup_req = 1'b1; cyc(2);
        chk("R9 drive K while suspended", drive_k, 1);
        line_state = 2'd2; cyc(3);
        chk("R8 own K not a resume", susp_sts, 1);
        rwkup_req = 1'b0; cyc(2);
        chk("R9 drive K released", drive_k, 0);
        chk("R8 wake flag", int_flags[2], 1);
        chk("R8 suspend status cleared", susp_sts, 0);
        chk("R8 returned to addressed", link_state, 2);
        chk("R8 address kept", dev_addr, 7'h05);
    endtask

    task automatic t_rwkup_ignored();
        rwkup_req = 1'b1; cyc(3);
        chk("R9 rwkup ignored when awake", drive_k, 0);
        chk("R9 state unchanged", link_state, 2);
        rwkup_req = 1'b0; cyc(1);
    endtask

    task automatic t_w1c();
        int_clr = 3'b011; cyc(1); int_clr = 3'b000; cyc(1);
        chk("R10 partial clear", int_flags, 3'b100);
        int_clr = 3'b100; cyc(1); int_clr = 3'b000; cyc(1);
        chk("R10 all cleared", int_flags, 3'b000);
    endtask

    task automatic t_collision();
        int seen;
        seen = 0;
        int_clr = 3'b001;
        line_state = 2'd1;
        for (int i = 0; i < 50; i++) begin
            cyc(1);
            if (int_flags[0]) seen++;
        end
        line_state = 2'd2;
        int_clr = 3'b000;
        cyc(1);
        chk("R10 set beats clear for one cycle", seen, 1);
    endtask

    task automatic t_reset_in_suspend();
        line_state = 2'd1; cyc(85);
        chk("R6 suspended again", susp_sts, 1);
        bus_reset();
        chk("R2 reset leaves suspend", susp_sts, 0);
        chk("R2 reset to default", link_state, 1);
        chk("R2 reset clears address", dev_addr, 0);
    endtask

    initial begin
        cyc(4);
        t_reset_state();
        rst_n = 1'b1;
        cyc(1);
        t_pullup();
        t_bus_reset();
        t_address();
        t_soft_disc();
        t_idle_break();
        t_suspend();
        t_remote_wakeup();
        t_rwkup_ignored();
        t_w1c();
        t_collision();
        t_reset_in_suspend();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule